// File: doc/BRIEF.md
# Asynchronous NAND Bus Cycle Sequencer

This block generates single bus cycles on an asynchronous (SDR) NAND flash port. A host asks for one cycle at a time: a command byte, an address byte, a data byte to write, or a data byte to read. The block then drives chip enable, the two latch enables, the write and read strobes and the 8-bit data bus. It watches the ready/busy line, returns the byte it read and raises a one-clock done pulse.

Every interval is a count of system clocks held in its own programmable timing register. These intervals are setup, strobe width, hold, the wait after a command for the device to go busy, the ready-to-read gap, the read access delay and the chip-enable access delay. The reset values meet the flash's minimum timings at a 100 MHz clock. Sequences of cycles that form page operations are left to the host.

Top module: `nand_async_seq`

## Requirements
- R1: After reset, ce_n, we_n and re_n are high, cle, ale, dq_oe, busy and done are low. The timing registers hold these defaults: write strobe 1, write hold 1, read strobe 1, read hold 1, setup 1, busy-wait 20, ready gap 2, read access 4, enable access 10.
- R2: A request is taken when req_valid is high while busy is low, and busy is high from the next clock until the cycle ends. A request presented while busy is high is ignored.
- R3: A command, address or write cycle goes through three phases. First, setup lasts the setup count: ce_n is low, the latch enables are set and the bus is driven. Next, we_n is low for the write-strobe count. Last, hold lasts the write-hold count, with we_n high and ce_n, the latch enables and the bus unchanged. we_n and re_n are never low together, and neither is low while ce_n is high.
- R4: req_type encodes the cycle: 0 command, 1 address, 2 write data, 3 read data. cle is high only in the active phases of a command cycle, and ale only in those of an address cycle.
- R5: After the hold phase of a command cycle, the pins return to idle with ce_n high. busy stays high for the busy-wait count before done.
- R6: A read cycle first waits until the ready/busy input, passed through two synchronizing flops, is high. It then spends the ready-gap count with the pins idle before its setup phase.
- R7: In a read, re_n stays low for N clocks, where N is the largest of three values: the read-strobe count, the read-access count, and the enable-access count minus the setup count. dq_in is captured on the clock edge that ends the last low clock and appears on rd_data. A hold phase of the read-hold count follows.
- R8: dq_oe is high only during the setup, strobe and hold phases of command, address and write cycles. It is never high during a read.
- R9: done is high for exactly one clock at the end of each cycle, and busy is low in that clock.
- R10: Timing registers can be written only when busy is low: cfg_we writes cfg_wdata into the register picked by cfg_sel. The select values are 0 write strobe, 1 write hold, 2 read strobe, 3 read hold, 4 setup, 5 busy-wait, 6 ready gap, 7 read access, 8 enable access. A written 0 is stored as 1, and select values above 8 are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| cfg_we | input | 1 | Timing register write strobe |
| cfg_sel | input | 4 | Timing register select |
| cfg_wdata | input | CW | Timing count to write |
| req_valid | input | 1 | Cycle request |
| req_type | input | 2 | Cycle kind |
| req_data | input | DW | Byte for command, address or write cycles |
| busy | output | 1 | Cycle in progress |
| done | output | 1 | One-clock end-of-cycle pulse |
| rd_data | output | DW | Last byte read |
| ce_n | output | 1 | Chip enable, active low |
| cle | output | 1 | Command latch enable |
| ale | output | 1 | Address latch enable |
| we_n | output | 1 | Write strobe, active low |
| re_n | output | 1 | Read strobe, active low |
| dq_out | output | DW | Bus output value |
| dq_oe | output | 1 | Bus output enable |
| dq_in | input | DW | Bus input value |
| rb | input | 1 | Ready/busy from device, high when ready |

## Verification
The checker watches several rules on every clock. The two strobes never overlap, and a strobe never falls with chip enable high. cle and ale are exclusive, and the bus is released whenever the read strobe is low. Chip enable and the latch enables are held across the rising write strobe. done lasts one clock with busy low, and an accepted request raises busy.

The exact phase lengths need the bench's cycle model. So do the read sample point, the synchronized wait for ready, the busy-wait after commands, the clamping of zero counts and the dropping of requests made while busy.

// File: rtl/nand_async_seq.sv
module nand_async_seq #(
  parameter int DW = 8,
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cfg_we,
  input  logic [3:0]    cfg_sel,
  input  logic [CW-1:0] cfg_wdata,
  input  logic          req_valid,
  input  logic [1:0]    req_type,
  input  logic [DW-1:0] req_data,
  output logic          busy,
  output logic          done,
  output logic [DW-1:0] rd_data,
  output logic          ce_n,
  output logic          cle,
  output logic          ale,
  output logic          we_n,
  output logic          re_n,
  output logic [DW-1:0] dq_out,
  output logic          dq_oe,
  input  logic [DW-1:0] dq_in,
  input  logic          rb
);
  localparam int NT = 9;

  typedef enum logic [2:0] {S_IDLE, S_RBW, S_RR, S_SU, S_STB, S_HLD, S_WB} st_t;

  function automatic logic [CW-1:0] dflt(input int i);
    case (i)
      5:       return CW'(20);
      6:       return CW'(2);
      7:       return CW'(4);
      8:       return CW'(10);
      default: return CW'(1);
    endcase
  endfunction

  logic [CW-1:0] tm [NT];
  st_t           st;
  logic [1:0]    kind;
  logic [DW-1:0] wdat;
  logic [CW-1:0] cnt, lim;
  logic          rs1, rs2;

  wire is_rd = (kind == 2'd3);
  wire act   = (st == S_SU) || (st == S_STB) || (st == S_HLD);

  wire rd_ready = (cnt >= tm[2]) && (cnt >= tm[7]) &&
                  (({1'b0, cnt} + {1'b0, tm[4]}) >= {1'b0, tm[8]});

  always_comb begin
    case (st)
      S_RR:    lim = tm[6];
      S_SU:    lim = tm[4];
      S_STB:   lim = tm[0];
      S_HLD:   lim = is_rd ? tm[3] : tm[1];
      S_WB:    lim = tm[5];
      default: lim = '0;
    endcase
  end

  wire last = (st == S_STB && is_rd) ? rd_ready : (cnt == lim);

  always_ff @(posedge clk) begin
    for (int i = 0; i < NT; i++) begin
      if (rst) tm[i] <= dflt(i);
      else if (cfg_we && st == S_IDLE && cfg_sel == 4'(i))
        tm[i] <= (cfg_wdata == '0) ? CW'(1) : cfg_wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st <= S_IDLE; cnt <= CW'(1); kind <= '0; wdat <= '0;
      rd_data <= '0; done <= 1'b0; rs1 <= 1'b0; rs2 <= 1'b0;
    end else begin
      rs1  <= rb;
      rs2  <= rs1;
      done <= 1'b0;
      cnt  <= cnt + CW'(1);
      case (st)
        S_IDLE: if (req_valid) begin
          kind <= req_type; wdat <= req_data; cnt <= CW'(1);
          st   <= (req_type == 2'd3) ? S_RBW : S_SU;
        end
        S_RBW: if (rs2) begin st <= S_RR; cnt <= CW'(1); end
        S_RR:  if (last) begin st <= S_SU; cnt <= CW'(1); end
        S_SU:  if (last) begin st <= S_STB; cnt <= CW'(1); end
        S_STB: if (last) begin
          if (is_rd) rd_data <= dq_in;
          st <= S_HLD; cnt <= CW'(1);
        end
        S_HLD: if (last) begin
          if (kind == 2'd0) begin st <= S_WB; cnt <= CW'(1); end
          else begin st <= S_IDLE; done <= 1'b1; end
        end
        S_WB:  if (last) begin st <= S_IDLE; done <= 1'b1; end
        default: st <= S_IDLE;
      endcase
    end
  end

  assign busy   = (st != S_IDLE);
  assign ce_n   = !act;
  assign cle    = act && (kind == 2'd0);
  assign ale    = act && (kind == 2'd1);
  assign we_n   = !(st == S_STB && !is_rd);
  assign re_n   = !(st == S_STB && is_rd);
  assign dq_oe  = act && !is_rd;
  assign dq_out = wdat;
endmodule

// File: rtl/nand_async_seq_chk.sv
module nand_async_seq_chk #(
  parameter int DW = 8
) (
  input logic clk,
  input logic rst,
  input logic req_valid,
  input logic busy,
  input logic done,
  input logic ce_n,
  input logic cle,
  input logic ale,
  input logic we_n,
  input logic re_n,
  input logic dq_oe
);
  p_no_overlap_r3: assert property (@(posedge clk) disable iff (rst) !(!we_n && !re_n));
  p_strobe_ce_r3: assert property (@(posedge clk) disable iff (rst) (!we_n || !re_n) |-> !ce_n);
  p_hold_latch_r3: assert property (@(posedge clk) disable iff (rst)
    $rose(we_n) |-> (!ce_n && $stable(cle) && $stable(ale) && $stable(dq_oe)));
  p_latch_excl_r4: assert property (@(posedge clk) disable iff (rst) !(cle && ale));
  p_bus_free_r8: assert property (@(posedge clk) disable iff (rst) !re_n |-> !dq_oe);
  p_accept_r2: assert property (@(posedge clk) disable iff (rst) (req_valid && !busy) |=> busy);
  p_done_pulse_r9: assert property (@(posedge clk) disable iff (rst) done |=> !done);
  p_done_idle_r9: assert property (@(posedge clk) disable iff (rst) done |-> !busy);
endmodule

bind nand_async_seq nand_async_seq_chk #(.DW(DW)) u_chk (
  .clk(clk), .rst(rst), .req_valid(req_valid), .busy(busy), .done(done),
  .ce_n(ce_n), .cle(cle), .ale(ale), .we_n(we_n), .re_n(re_n), .dq_oe(dq_oe)
);

// File: tb/test_nand_async_seq.sv
module test_nand_async_seq;
  localparam int DW = 8;
  localparam int CW = 8;
  localparam logic [5:0] IDLE_V = 6'b100110;

  logic clk = 1'b0, rst = 1'b1;
  logic cfg_we = 0; logic [3:0] cfg_sel = 0; logic [CW-1:0] cfg_wdata = 0;
  logic req_valid = 0; logic [1:0] req_type = 0; logic [DW-1:0] req_data = 0;
  logic busy, done, ce_n, cle, ale, we_n, re_n, dq_oe;
  logic [DW-1:0] rd_data, dq_out;
  logic [DW-1:0] dq_in = 0;
  logic rb = 1'b1;

  always #5 clk = ~clk;

  nand_async_seq #(.DW(DW), .CW(CW)) i_nand_async_seq (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
    .req_valid(req_valid), .req_type(req_type), .req_data(req_data),
    .busy(busy), .done(done), .rd_data(rd_data), .ce_n(ce_n), .cle(cle), .ale(ale),
    .we_n(we_n), .re_n(re_n), .dq_out(dq_out), .dq_oe(dq_oe), .dq_in(dq_in), .rb(rb));

  int checks = 0, errors = 0;
  bit finished = 0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  // reference model
  int mt [9];
  logic [6:0] q [$];
  bit m_wait, m_done, mr1, mr2;
  logic [1:0] m_kind;
  logic [DW-1:0] m_dat, m_rd;
  bit model_on = 0;

  function automatic logic [5:0] vec(input logic [1:0] k, input int ph);
    logic [5:0] v;
    v = {1'b0, k == 2'd0, k == 2'd1, 1'b1, 1'b1, k != 2'd3};
    if (ph == 1) begin
      if (k == 2'd3) v[1] = 1'b0; else v[2] = 1'b0;
    end
    return v;
  endfunction

  task automatic push(input int n, input logic [6:0] e);
    for (int i = 0; i < n; i++) q.push_back(e);
  endtask

  always @(posedge clk) begin
    if (rst) begin
      q.delete(); m_wait = 0; m_done = 0; mr1 = 0; mr2 = 0; m_rd = 0; m_kind = 0; m_dat = 0;
      for (int i = 0; i < 9; i++) mt[i] = 1;
      mt[5] = 20; mt[6] = 2; mt[7] = 4; mt[8] = 10;
    end else begin
      bit bsy;
      m_done = 0;
      bsy = m_wait || (q.size() > 0);
      if (!bsy && cfg_we && cfg_sel < 9) mt[cfg_sel] = (cfg_wdata == 0) ? 1 : int'(cfg_wdata);
      if (!bsy) begin
        if (req_valid) begin
          m_kind = req_type; m_dat = req_data;
          if (req_type == 2'd3) m_wait = 1;
          else begin
            push(mt[4], {1'b0, vec(m_kind, 0)});
            push(mt[0], {1'b0, vec(m_kind, 1)});
            push(mt[1], {1'b0, vec(m_kind, 0)});
            if (m_kind == 2'd0) push(mt[5], {1'b0, IDLE_V});
          end
        end
      end else if (m_wait) begin
        if (mr2) begin
          int n;
          m_wait = 0;
          n = mt[2];
          if (mt[7] > n) n = mt[7];
          if (mt[8] - mt[4] > n) n = mt[8] - mt[4];
          push(mt[6], {1'b0, IDLE_V});
          push(mt[4], {1'b0, vec(m_kind, 0)});
          push(n - 1, {1'b0, vec(m_kind, 1)});
          q.push_back({1'b1, vec(m_kind, 1)});
          push(mt[3], {1'b0, vec(m_kind, 0)});
        end
      end else begin
        logic [6:0] e;
        e = q.pop_front();
        if (e[6]) m_rd = dq_in;
        if (q.size() == 0) m_done = 1;
      end
      mr2 = mr1; mr1 = rb;
    end
  end

  // per-cycle comparison and strobe-width monitors
  int wl = 0, rl = 0, last_wl = 0, last_rl = 0;
  always @(negedge clk) begin
    if (!we_n) wl++; else if (wl != 0) begin last_wl = wl; wl = 0; end
    if (!re_n) rl++; else if (rl != 0) begin last_rl = rl; rl = 0; end
    if (model_on && !rst) begin
      logic [5:0] ev;
      ev = (q.size() > 0) ? q[0][5:0] : IDLE_V;
      chk(ce_n == ev[5], "R3 ce_n", ce_n, ev[5]);
      chk({cle, ale} == ev[4:3], "R4 cle/ale", {cle, ale}, ev[4:3]);
      chk(we_n == ev[2], "R3 we_n", we_n, ev[2]);
      chk(re_n == ev[1], "R7 re_n", re_n, ev[1]);
      chk(dq_oe == ev[0], "R8 dq_oe", dq_oe, ev[0]);
      chk(busy == (m_wait || q.size() > 0), "R2 busy", busy, m_wait || q.size() > 0);
      chk(done == m_done, "R9 R5 done", done, m_done);
      chk(rd_data == m_rd, "R7 rd_data", rd_data, m_rd);
      if (dq_oe) chk(dq_out == m_dat, "R3 dq_out", dq_out, m_dat);
    end
    dq_in <= dq_in + 8'h3b;
  end

  task automatic cfg(input int sel, input int val);
    @(negedge clk); cfg_we = 1; cfg_sel = 4'(sel); cfg_wdata = CW'(val);
    @(negedge clk); cfg_we = 0;
  endtask

  task automatic req(input logic [1:0] t, input logic [7:0] d);
    @(negedge clk); req_valid = 1; req_type = t; req_data = d;
    @(negedge clk); req_valid = 0;
    do @(negedge clk); while (!done);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog actual=hung expected=done");
    summary();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R1 reset state
    chk({ce_n, cle, ale, we_n, re_n, dq_oe} == IDLE_V, "R1 idle pins",
        {ce_n, cle, ale, we_n, re_n, dq_oe}, IDLE_V);
    chk(!busy && !done, "R1 busy/done", {busy, done}, 0);
    model_on = 1;
    // default timing, each kind
    req(2'd0, 8'h70);
    req(2'd1, 8'h12);
    req(2'd2, 8'ha5);
    req(2'd3, 8'h00);
    chk(last_rl == 9, "R1 R7 default read low width", last_rl, 9);
    chk(last_wl == 1, "R1 R3 default write low width", last_wl, 1);
    // R10 reprogram, incl. zero clamp
    cfg(0, 3); cfg(1, 2); cfg(4, 2); cfg(5, 4);
    req(2'd0, 8'h90);
    chk(last_wl == 3, "R10 write strobe width", last_wl, 3);
    cfg(0, 0);
    req(2'd2, 8'h5a);
    chk(last_wl == 1, "R10 zero clamps to one", last_wl, 1);
    cfg(12, 7);
    req(2'd1, 8'h33);
    // R7 access delay dominates
    cfg(2, 2); cfg(7, 6); cfg(8, 3); cfg(6, 3);
    req(2'd3, 8'h00);
    chk(last_rl == 6, "R7 access-limited low width", last_rl, 6);
    // R6 wait for ready
    rb = 0;
    @(negedge clk); req_valid = 1; req_type = 2'd3;
    @(negedge clk); req_valid = 0;
    repeat (8) @(negedge clk);
    chk(re_n && busy && ce_n, "R6 holds while not ready", {re_n, busy, ce_n}, 3'b111);
    rb = 1;
    do @(negedge clk); while (!done);
    // R2 request during busy ignored, R10 write during busy ignored
    @(negedge clk); req_valid = 1; req_type = 2'd2; req_data = 8'hc3;
    @(negedge clk); req_valid = 1; req_type = 2'd0; req_data = 8'hff;
    cfg_we = 1; cfg_sel = 4'd0; cfg_wdata = 8'd5;
    @(negedge clk); req_valid = 0; cfg_we = 0;
    do @(negedge clk); while (!done);
    @(negedge clk);
    chk(!busy, "R2 busy request dropped", busy, 0);
    req(2'd2, 8'h11);
    chk(last_wl == 1, "R10 write while busy ignored", last_wl, 1);
    repeat (4) @(negedge clk);
    summary();
  end
endmodule